// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog with a small register bank behind a simple 32-bit register bus. Software sets a timeout in ticks and reloads the countdown by writing the reload field. It can halt and resume the countdown through a control bit. Each pulse on `tick_en` is one watchdog tick; a tick is 0.6 s, so a timeout of S seconds is programmed as S × 10 / 6 ticks. The tick enable comes from a divider elsewhere on the chip.

The first expiry sets a timeout flag and restarts the countdown. If that flag is still set when the count runs out again, a second-timeout flag is raised. A one-cycle reset request is also issued unless `no_reboot` is high; when it is high, a boot flag is raised instead. Byte writes to the software data-in and data-out registers raise their own status bits. Every status bit is cleared by writing a one to it.

The bus is dword-addressed (`bus_addr` is the word index) with byte strobes. Related narrow registers share a word, so a single access returns a pair. Read data is registered and valid in the cycle after `bus_rd`, and it holds until the next read.

Top module: `wdt_regblock`

## Requirements
- R1: After reset the five words read: word 0 = 0x00000000, word 1 = 0x00000000, word 2 = 0x00080000, word 3 = 0x03000000, word 4 = 0x00000004.
- R2: The timeout register (word 4, bits 15:0) keeps only its low 10 bits, so writing 0xFFFF reads back 0x03FF. A stored timeout of 0 or 1 loads the counter with 2.
- R3: Any write with strobe 0 or 1 set on word 0 reloads the counter from the timeout. Word 0 bits 15:0 then read the loaded value, which drops by one on each later tick.
- R4: A tick that finds the counter at 1 (or 0) is an expiry. It sets status-1 bit 3 and reloads the counter. With a timeout of 0x3FF, after 1022 ticks the counter reads 1 and bit 3 is clear; the next tick sets it.
- R5: An expiry while status-1 bit 3 is already set raises status-2 bit 1 (word 1 bit 17). An expiry after bit 3 was cleared sets only bit 3 again.
- R6: On a second timeout with `no_reboot` low, `reset_req` is high for exactly one cycle. With `no_reboot` high, no pulse occurs and status-2 bit 2 (word 1 bit 18) is raised.
- R7: Control-1 bit 11 (word 2 bit 11) halts the countdown while set. Clearing it resumes the count from the held value. It reads 0 after reset.
- R8: A write with strobe 2 on word 0 stores data-in (bits 23:16) and sets status-1 bit 1. A write with strobe 3 stores data-out (bits 31:24) and sets status-1 bit 2. Neither write reloads the counter.
- R9: Writing a one to a status bit clears it (status-1 in word 1 bits 15:0, status-2 in bits 31:16). Writing zeros leaves the status unchanged.
- R10: Control-2 (word 2 bits 31:16), message bytes (word 3 bits 7:0 and 15:8), the count byte (bits 23:16) and the software IRQ byte (bits 31:24) store writes per byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One watchdog tick per cycle high |
| no_reboot | input | 1 | Blocks the reset request on second timeout |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word index |
| bus_wstrb | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest state to reach is the second timeout. It needs two full countdowns with the timeout flag left set between them, and `no_reboot` decides the outcome. The bench programs a short timeout and drives exactly the number of ticks needed. It first clears the flag after one expiry to show that a plain expiry repeats. It then leaves the flag set and counts `reset_req` cycles and the longest high run, for each setting of `no_reboot`. The 10-bit boundary is reached by writing 0xFFFF and stepping 1022 ticks before the final expiring tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int W_CNT = 0;
  localparam int W_STS = 1;
  localparam int W_CTL = 2;
  localparam int W_MSG = 3;
  localparam int W_TMO = 4;

  localparam int S1_SWDIN  = 1;
  localparam int S1_SWDOUT = 2;
  localparam int S1_TMO    = 3;
  localparam int S2_SECOND = 1;
  localparam int S2_BOOT   = 2;
  localparam int C1_HALT   = 11;

  localparam logic [15:0] CTL2_RST  = 16'h0008;
  localparam logic [7:0]  SWIRQ_RST = 8'h03;
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick_en && !halt && !reload_req && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (reload_req)      cnt <= load_val;
    else if (expire)          cnt <= load_val;
    else if (tick_en && !halt) cnt <= cnt - ONE;
  end

  // R3: one tick removes exactly one count
  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !halt && !reload_req && cnt > ONE) |=> cnt == $past(cnt) - ONE);
  // R3: reload takes the load value
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    reload_req |=> cnt == $past(load_val));
  // R4: expiry restarts the count
  p_expire_reload_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == $past(load_val));
  // R7: halted counter holds
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload_req) |=> $stable(cnt));
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        expire,
  input  logic        no_reboot,
  input  logic        din_wr,
  input  logic        dout_wr,
  input  logic [15:0] clr1,
  input  logic [15:0] clr2,
  output logic [15:0] sts1,
  output logic [15:0] sts2,
  output logic        reset_req
);
  logic        second;
  logic [15:0] set1, set2;

  assign second = expire && sts1[S1_TMO];

  always_comb begin
    set1 = '0;
    set2 = '0;
    set1[S1_TMO]    = expire;
    set1[S1_SWDIN]  = din_wr;
    set1[S1_SWDOUT] = dout_wr;
    set2[S2_SECOND] = second;
    set2[S2_BOOT]   = second && no_reboot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts1      <= '0;
      sts2      <= '0;
      reset_req <= 1'b0;
    end else begin
      sts1      <= (sts1 & ~clr1) | set1;
      sts2      <= (sts2 & ~clr2) | set2;
      reset_req <= second && !no_reboot;
    end
  end

  // R6: request lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  // R6: request only follows an expiry with reboot allowed
  p_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> ($past(expire) && !$past(no_reboot)));
  // R5: a request comes with the second-timeout flag
  p_second_flag_r5: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> sts2[S2_SECOND]);
  // R4: expiry raises the timeout flag
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> sts1[S1_TMO]);
  // R5: a first expiry leaves status-2 alone
  p_first_only_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && !sts1[S1_TMO] && clr2 == 16'h0) |=> $stable(sts2));
  // R9: cleared bits drop when nothing sets them
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (clr1 != 16'h0 && !expire && !din_wr && !dout_wr) |=> (sts1 & $past(clr1)) == 16'h0);
endmodule

// File: rtl/wdt_regblock.sv
module wdt_regblock
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_LOAD = 2,
  parameter int ADDR_W   = 3,
  parameter int TMO_RST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              no_reboot,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_wstrb,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              reset_req
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LOAD);

  logic [3:0]       wb0, wb1, wb2, wb3, wb4;
  logic [7:0]       din, dout, msg1, msg2, wdcnt, swirq;
  logic [15:0]      ctrl2, tmo_next;
  logic             halt;
  logic [CNT_W-1:0] tmo, load_val, cnt;
  logic             expire, reload_req, din_wr, dout_wr;
  logic [15:0]      clr1, clr2, sts1, sts2;
  logic [15:0]      ctrl1_view;

  function automatic logic [7:0] merge(input logic en, input logic [7:0] nw, input logic [7:0] old);
    return en ? nw : old;
  endfunction

  always_comb begin
    wb0 = (bus_wr && bus_addr == ADDR_W'(W_CNT)) ? bus_wstrb : 4'h0;
    wb1 = (bus_wr && bus_addr == ADDR_W'(W_STS)) ? bus_wstrb : 4'h0;
    wb2 = (bus_wr && bus_addr == ADDR_W'(W_CTL)) ? bus_wstrb : 4'h0;
    wb3 = (bus_wr && bus_addr == ADDR_W'(W_MSG)) ? bus_wstrb : 4'h0;
    wb4 = (bus_wr && bus_addr == ADDR_W'(W_TMO)) ? bus_wstrb : 4'h0;
  end

  assign reload_req = |wb0[1:0];
  assign din_wr     = wb0[2];
  assign dout_wr    = wb0[3];
  assign clr1 = {wb1[1] ? bus_wdata[15:8]  : 8'h0, wb1[0] ? bus_wdata[7:0]   : 8'h0};
  assign clr2 = {wb1[3] ? bus_wdata[31:24] : 8'h0, wb1[2] ? bus_wdata[23:16] : 8'h0};
  assign tmo_next = {merge(wb4[1], bus_wdata[15:8], 8'(16'(tmo) >> 8)),
                     merge(wb4[0], bus_wdata[7:0],  8'(tmo))};
  assign load_val = (tmo < MIN_V) ? MIN_V : tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      din   <= '0;
      dout  <= '0;
      halt  <= 1'b0;
      ctrl2 <= CTL2_RST;
      msg1  <= '0;
      msg2  <= '0;
      wdcnt <= '0;
      swirq <= SWIRQ_RST;
      tmo   <= CNT_W'(TMO_RST);
    end else begin
      din   <= merge(wb0[2], bus_wdata[23:16], din);
      dout  <= merge(wb0[3], bus_wdata[31:24], dout);
      if (wb2[1]) halt <= bus_wdata[C1_HALT];
      ctrl2 <= {merge(wb2[3], bus_wdata[31:24], ctrl2[15:8]),
                merge(wb2[2], bus_wdata[23:16], ctrl2[7:0])};
      msg1  <= merge(wb3[0], bus_wdata[7:0],   msg1);
      msg2  <= merge(wb3[1], bus_wdata[15:8],  msg2);
      wdcnt <= merge(wb3[2], bus_wdata[23:16], wdcnt);
      swirq <= merge(wb3[3], bus_wdata[31:24], swirq);
      if (|wb4[1:0]) tmo <= tmo_next[CNT_W-1:0];
    end
  end

  wdt_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .halt(halt),
    .reload_req(reload_req), .load_val(load_val), .cnt(cnt), .expire(expire)
  );

  wdt_status u_status (
    .clk(clk), .rst(rst), .expire(expire), .no_reboot(no_reboot),
    .din_wr(din_wr), .dout_wr(dout_wr), .clr1(clr1), .clr2(clr2),
    .sts1(sts1), .sts2(sts2), .reset_req(reset_req)
  );

  always_comb begin
    ctrl1_view = '0;
    ctrl1_view[C1_HALT] = halt;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (int'(bus_addr))
        W_CNT:   bus_rdata <= {dout, din, 16'(cnt)};
        W_STS:   bus_rdata <= {sts2, sts1};
        W_CTL:   bus_rdata <= {ctrl2, ctrl1_view};
        W_MSG:   bus_rdata <= {swirq, wdcnt, msg2, msg1};
        W_TMO:   bus_rdata <= {16'h0, 16'(tmo)};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R2: a reload never loads below the minimum
  p_min_load_r2: assert property (@(posedge clk) disable iff (rst)
    reload_req |=> cnt >= MIN_V);
endmodule

// File: tb/wdt_regblock_tb.sv
`timescale 1ns/1ps
module wdt_regblock_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        no_reboot = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int run = 0;
  int max_run = 0;

  always #4 clk = ~clk;

  wdt_regblock u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .no_reboot(no_reboot),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  always @(negedge clk) begin
    if (rst) begin
      run <= 0;
    end else if (reset_req) begin
      pulses <= pulses + 1;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; no_reboot = 1'b0; tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pulses = 0; max_run = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] s, input logic [31:0] d);
    bus_addr = a; bus_wstrb = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic t_defaults();
    logic [31:0] d;
    do_reset();
    rd(0, d); chk("R1 word0", d, 32'h0000_0000);
    rd(1, d); chk("R1 word1", d, 32'h0000_0000);
    rd(2, d); chk("R1 word2", d, 32'h0008_0000);
    rd(3, d); chk("R1 word3", d, 32'h0300_0000);
    rd(4, d); chk("R1 word4", d, 32'h0000_0004);
  endtask

  task automatic t_mask_clamp();
    logic [31:0] d;
    do_reset();
    wr(4, 4'b0011, 32'h0000_FFFF);
    rd(4, d); chk("R2 mask", d, 32'h0000_03FF);
    wr(4, 4'b0011, 32'h0); wr(0, 4'b0001, 32'h0);
    rd(0, d); chk("R2 clamp zero", d, 32'h0000_0002);
    wr(4, 4'b0011, 32'h1); wr(0, 4'b0010, 32'h0);
    rd(0, d); chk("R2 clamp one", d, 32'h0000_0002);
  endtask

  task automatic t_reload_count();
    logic [31:0] d;
    do_reset();
    wr(4, 4'b0011, 32'd8); wr(0, 4'b0011, 32'h0);
    rd(0, d); chk("R3 reload value", d, 32'd8);
    ticks(1); rd(0, d); chk("R3 one tick", d, 32'd7);
    ticks(3); rd(0, d); chk("R3 four ticks", d, 32'd4);
    wr(0, 4'b0001, 32'hFF); rd(0, d); chk("R3 reload again", d, 32'd8);
  endtask

  task automatic t_max();
    logic [31:0] d;
    do_reset();
    wr(4, 4'b0011, 32'h0000_FFFF); wr(0, 4'b0011, 32'h0);
    ticks(1022);
    rd(0, d); chk("R4 count at one", d, 32'd1);
    rd(1, d); chk("R4 no flag yet", d, 32'h0);
    ticks(1);
    rd(1, d); chk("R4 flag set", d, 32'h0000_0008);
    rd(0, d); chk("R4 reloaded", d, 32'h0000_03FF);
  endtask

  task automatic t_second(input logic nr);
    logic [31:0] d;
    do_reset();
    no_reboot = nr;
    wr(4, 4'b0011, 32'd4); wr(0, 4'b0011, 32'h0);
    ticks(4); rd(1, d); chk("R4 first expiry", d, 32'h0000_0008);
    wr(1, 4'b0001, 32'h08); rd(1, d); chk("R9 clear flag", d, 32'h0);
    ticks(4); rd(1, d); chk("R5 only timeout again", d, 32'h0000_0008);
    ticks(4); rd(1, d);
    if (nr) begin
      chk("R6 boot flag, no request", d, 32'h0006_0008);
      chk("R6 no pulse", 32'(pulses), 32'd0);
      wr(1, 4'b1111, d); rd(1, d); chk("R9 clear both", d, 32'h0);
    end else begin
      chk("R5 second flag", d, 32'h0002_0008);
      chk("R6 one pulse", 32'(pulses), 32'd1);
      chk("R6 pulse width", 32'(max_run), 32'd1);
    end
  endtask

  task automatic t_halt();
    logic [31:0] d;
    do_reset();
    wr(4, 4'b0011, 32'd6);
    wr(2, 4'b0010, 32'h0000_0800);
    wr(0, 4'b0011, 32'h0);
    ticks(3); rd(0, d); chk("R7 held", d, 32'd6);
    rd(2, d); chk("R7 halt bit", d, 32'h0008_0800);
    wr(2, 4'b0010, 32'h0);
    ticks(2); rd(0, d); chk("R7 resumed", d, 32'd4);
  endtask

  task automatic t_swbits();
    logic [31:0] d;
    do_reset();
    wr(0, 4'b0100, 32'h00AB_0000);
    rd(1, d); chk("R8 data-in status", d, 32'h0000_0002);
    wr(0, 4'b1000, 32'hCD00_0000);
    rd(1, d); chk("R8 data-out status", d, 32'h0000_0006);
    rd(0, d); chk("R8 bytes stored, no reload", d, 32'hCDAB_0000);
    wr(1, 4'b1111, 32'h0); rd(1, d); chk("R9 zeros keep", d, 32'h0000_0006);
    wr(1, 4'b0001, 32'h04); rd(1, d); chk("R9 clear one bit", d, 32'h0000_0002);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    do_reset();
    wr(3, 4'b1111, 32'hA55A_3CC3); rd(3, d); chk("R10 message word", d, 32'hA55A_3CC3);
    wr(3, 4'b0001, 32'hFFFF_FF00); rd(3, d); chk("R10 byte strobe", d, 32'hA55A_3C00);
    wr(2, 4'b1100, 32'h1234_0000); rd(2, d); chk("R10 control-2", d, 32'h1234_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R-all watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_defaults();
    t_mask_clamp();
    t_reload_count();
    t_max();
    t_second(1'b0);
    t_second(1'b1);
    t_halt();
    t_swbits();
    t_storage();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule